// File: doc/BRIEF.md
# SPI Master Port with Transmit and Receive FIFOs

This block is a memory-mapped synchronous serial port that works only as an SPI master in clock mode 0. Software writes frames into an eight-entry transmit queue through a data register. A shift engine takes them oldest first and clocks each one out MSB first on `mosi` while it samples `miso`. It pushes every received frame into an eight-entry receive queue, which software drains through the same data register. The frame length is programmable from 1 to 16 bits. A loopback control bit sends each transmitted frame straight into the receive queue instead of the `miso` bits. A level-sensitive interrupt combines a receive-half-full condition and a transmit-half-empty condition through a mask register.

The engine never overruns the receive queue. It does not start a frame unless the receive queue has room, and it waits, with chip select released, until software reads an entry. The engine state machine has six states:
- ST_IDLE: chip select high. It moves to ST_LEAD when a frame may start.
- ST_LEAD: the first data bit is set up on `mosi` for one half period. It moves to ST_SCK_HI, sampling `miso` on the way.
- ST_SCK_HI: clock high. It moves to ST_SCK_LO to shift the next bit, or to ST_COMMIT after the last bit.
- ST_SCK_LO: clock low. It moves to ST_SCK_HI, sampling `miso` on the way.
- ST_COMMIT: one cycle that writes the receive queue. It moves to ST_GAP.
- ST_GAP: a low half period with chip select held. It moves to ST_LEAD for the next queued frame, or to ST_IDLE.

The register bus uses word addresses; byte offsets are given below. 0x00 is frame config (bits 3:0 = frame bits - 1). 0x04 is control: bit 0 loopback, bit 1 enable, bit 2 slave request, bit 3 slave output disable (stored only). 0x08 is data. 0x0C is status. 0x10 is prescaler (8 bits). 0x14 is interrupt mask. 0x18 is raw interrupt. 0x1C is masked interrupt. 0xFE0 to 0xFFC hold identification bytes.

Top module: `ssp_master`

## Requirements
- R1: After reset, status reads 0x03, raw interrupt reads 0x08, `cs_n` is high, `sclk` is low and `irq` is low.
- R2: The frame length is frame config bits 3:0 plus one. Data written to the transmit queue and data placed in the receive queue keep only that many low bits.
- R3: Each queue holds 8 entries. A data write while the transmit queue holds 8 entries is dropped.
- R4: A data read returns and removes the oldest receive entry. A read of an empty receive queue returns the last value read, or 0 if none was read since reset.
- R5: Status bits: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 engine busy. Upper bits read 0.
- R6: Raw interrupt bit 2 is 1 while the receive queue holds 4 or more entries. Bit 3 is 1 while the transmit queue holds 4 or fewer. Bits 0 and 1 read 0.
- R7: The masked interrupt register returns raw AND mask, and `irq` is 1 exactly when that AND is nonzero.
- R8: A frame starts only while enable is 1, slave request is 0, the transmit queue is non-empty and the receive queue holds fewer than 8 entries. A stalled frame starts once a receive entry is read, and the order of frames is preserved.
- R9: With loopback set, each transmitted frame enters the receive queue unchanged.
- R10: Frames go out MSB first in mode 0: `sclk` idles low, `mosi` changes after falling edges, and `miso` is sampled at rising edges. Without loopback, the sampled bits form the received frame.
- R11: `sclk` stays high and low for H system clocks each. H is the prescaler with bit 0 cleared, and at least 2. `cs_n` stays low across back-to-back frames. Status busy is 1 while a frame is in progress.
- R12: With enable and slave request both set, `unsupported` is 1 and no frame starts.
- R13: Config, control, prescaler and mask read back their stored fields. The eight words from 0xFE0 return identification bytes 0x96, 0xC1, 0x07, 0x00, 0xE4, 0x11, 0x3C, 0x5A in ascending address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | Word address (byte offset bits 11:2) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive queue at the data address) |
| wdata | input | 16 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as addr |
| irq | output | 1 | Combined masked interrupt |
| unsupported | output | 1 | Slave mode requested while enabled |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest condition to reach is the receive-full stall. The transmit queue still holds frames while the engine must wait, and it must resume in order after a single read. The bench loads eight frames with the port disabled, enables loopback so the receive queue fills, then queues three more frames. It checks that nothing moves for several hundred cycles and then drains all eleven frames one read at a time. The bench also ties `miso` to the inverse of `mosi`, which checks the bit order and the sample edge without loopback.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SCK_HI,
        ST_SCK_LO,
        ST_COMMIT,
        ST_GAP
    } eng_state_t;

    localparam logic [9:0] WA_FRAME = 10'h000;
    localparam logic [9:0] WA_CTRL  = 10'h001;
    localparam logic [9:0] WA_DATA  = 10'h002;
    localparam logic [9:0] WA_STAT  = 10'h003;
    localparam logic [9:0] WA_PRESC = 10'h004;
    localparam logic [9:0] WA_MASK  = 10'h005;
    localparam logic [9:0] WA_RAW   = 10'h006;
    localparam logic [9:0] WA_MIS   = 10'h007;
    localparam logic [6:0] ID_WIN   = 7'h7F;

    localparam int CTRL_LOOP  = 0;
    localparam int CTRL_EN    = 1;
    localparam int CTRL_SLAVE = 2;

    localparam int IRQ_RXH = 2;
    localparam int IRQ_TXH = 3;

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [W-1:0]             push_data,
    input  logic                     pop,
    output logic [W-1:0]             head,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = AW + 1;
    localparam logic [CNTW-1:0] FULL_C = CNTW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic          push_ok, pop_ok;

    assign push_ok = push && (count != FULL_C);
    assign pop_ok  = pop && (count != '0);
    assign head    = mem[rptr_q];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wptr_q <= wptr_q + 1'b1;
            if (pop_ok)  rptr_q <= rptr_q + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_C);

    assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count == FULL_C) |=> count == FULL_C);

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
    import ssp_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          slave_req,
    input  logic          loopback,
    input  logic [CW-1:0] frame_m1,
    input  logic [6:0]    presc_hi,
    input  logic          tx_avail,
    input  logic          rx_room,
    input  logic [W-1:0]  tx_data,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [W-1:0]  rx_data,
    output logic          busy,
    output logic          sclk,
    output logic          cs_n,
    output logic          mosi,
    input  logic          miso
);
    localparam logic [CW:0] W_C = (CW+1)'(W);

    eng_state_t    state_q, state_d;
    logic [7:0]    timer_q, half;
    logic [CW:0]   bits_left_q, nbits, shamt;
    logic [W-1:0]  txsh_q, rxsh_q, frame_q;
    logic          tmo, start_ok, load;

    assign nbits    = {1'b0, frame_m1} + 1'b1;
    assign shamt    = W_C - nbits;
    assign half     = (presc_hi == 7'd0) ? 8'd2 : {presc_hi, 1'b0};
    assign tmo      = (timer_q == 8'd0);
    assign start_ok = enable && !slave_req && tx_avail && rx_room;
    assign load     = ((state_q == ST_IDLE) || (state_q == ST_GAP && tmo)) && start_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok) state_d = ST_LEAD;
            ST_LEAD:   if (tmo) state_d = ST_SCK_HI;
            ST_SCK_HI: if (tmo) state_d = (bits_left_q == 1) ? ST_COMMIT : ST_SCK_LO;
            ST_SCK_LO: if (tmo) state_d = ST_SCK_HI;
            ST_COMMIT: state_d = ST_GAP;
            ST_GAP:    if (tmo) state_d = start_ok ? ST_LEAD : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q     <= '0;
            bits_left_q <= '0;
            txsh_q      <= '0;
            rxsh_q      <= '0;
            frame_q     <= '0;
        end else begin
            if (state_d != state_q) timer_q <= half - 8'd1;
            else if (!tmo)          timer_q <= timer_q - 8'd1;

            if (load) begin
                frame_q     <= tx_data;
                txsh_q      <= tx_data << shamt;
                bits_left_q <= nbits;
                rxsh_q      <= '0;
            end else if (tmo && (state_q == ST_LEAD || state_q == ST_SCK_LO)) begin
                rxsh_q <= {rxsh_q[W-2:0], miso};
            end else if (tmo && state_q == ST_SCK_HI) begin
                bits_left_q <= bits_left_q - 1'b1;
                if (bits_left_q != 1) txsh_q <= {txsh_q[W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        tx_pop  = load;
        rx_push = (state_q == ST_COMMIT);
        rx_data = loopback ? frame_q : rxsh_q;
        busy    = (state_q != ST_IDLE);
        cs_n    = (state_q == ST_IDLE);
        sclk    = (state_q == ST_SCK_HI);
        mosi    = txsh_q[W-1];
    end

    assert_start_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (enable && !slave_req && rx_room && tx_avail));

    assert_sclk_framed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    assert_slave_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && slave_req && cs_n) |=> cs_n);

endmodule

// File: rtl/ssp_master.sv
module ssp_master
    import ssp_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          DEPTH    = 8,
    parameter logic [63:0] ID_BYTES = 64'h5A3C_11E4_0007_C196
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [11:2]   addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [15:0]   wdata,
    output logic [31:0]   rdata,
    output logic          irq,
    output logic          unsupported,
    output logic          sclk,
    output logic          cs_n,
    output logic          mosi,
    input  logic          miso
);
    localparam int CW   = $clog2(DW);
    localparam int CNTW = $clog2(DEPTH) + 1;
    localparam logic [CNTW-1:0] FULL_C = CNTW'(DEPTH);
    localparam logic [CNTW-1:0] HALF_C = CNTW'(DEPTH / 2);

    logic [CW-1:0] frame_q;
    logic [3:0]    ctrl_q;
    logic [7:0]    presc_q;
    logic [3:0]    mask_q;
    logic [DW-1:0] last_rx_q;

    logic [DW-1:0]   fmask, tx_head, rx_head, eng_rx;
    logic [CNTW-1:0] tx_cnt, rx_cnt;
    logic            tx_push, tx_pop, rx_push, rx_pop, busy;
    logic [CW:0]     nbits;
    logic [3:0]      raw, mis;
    logic [4:0]      status;

    assign nbits   = {1'b0, frame_q} + 1'b1;
    assign fmask   = ~({DW{1'b1}} << nbits);
    assign tx_push = wr_en && (addr == WA_DATA);
    assign rx_pop  = rd_en && (addr == WA_DATA) && (rx_cnt != '0);

    ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(wdata[DW-1:0] & fmask),
        .pop(tx_pop), .head(tx_head), .count(tx_cnt)
    );

    ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(eng_rx & fmask),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt)
    );

    ssp_engine #(.W(DW), .CW(CW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .enable(ctrl_q[CTRL_EN]), .slave_req(ctrl_q[CTRL_SLAVE]),
        .loopback(ctrl_q[CTRL_LOOP]), .frame_m1(frame_q),
        .presc_hi(presc_q[7:1]),
        .tx_avail(tx_cnt != '0), .rx_room(rx_cnt != FULL_C),
        .tx_data(tx_head), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_data(eng_rx), .busy(busy),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q   <= '0;
            ctrl_q    <= '0;
            presc_q   <= '0;
            mask_q    <= '0;
            last_rx_q <= '0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    WA_FRAME: frame_q <= wdata[CW-1:0];
                    WA_CTRL:  ctrl_q  <= wdata[3:0];
                    WA_PRESC: presc_q <= wdata[7:0];
                    WA_MASK:  mask_q  <= wdata[3:0];
                    default:  ;
                endcase
            end
            if (rx_pop) last_rx_q <= rx_head;
        end
    end

    always_comb begin
        raw          = '0;
        raw[IRQ_RXH] = (rx_cnt >= HALF_C);
        raw[IRQ_TXH] = (tx_cnt <= HALF_C);
        mis          = raw & mask_q;
        irq          = |mis;
        unsupported  = ctrl_q[CTRL_EN] && ctrl_q[CTRL_SLAVE];
        status       = {busy, rx_cnt == FULL_C, rx_cnt != '0,
                        tx_cnt != FULL_C, tx_cnt == '0};
    end

    always_comb begin
        rdata = '0;
        if (addr[11:5] == ID_WIN) begin
            rdata[7:0] = ID_BYTES[addr[4:2]*8 +: 8];
        end else begin
            unique case (addr)
                WA_FRAME: rdata[CW-1:0] = frame_q;
                WA_CTRL:  rdata[3:0]    = ctrl_q;
                WA_DATA:  rdata[DW-1:0] = (rx_cnt != '0) ? rx_head : last_rx_q;
                WA_STAT:  rdata[4:0]    = status;
                WA_PRESC: rdata[7:0]    = presc_q;
                WA_MASK:  rdata[3:0]    = mask_q;
                WA_RAW:   rdata[3:0]    = raw;
                WA_MIS:   rdata[3:0]    = mis;
                default:  rdata         = '0;
            endcase
        end
    end

    assert_irq_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[IRQ_TXH] && tx_cnt <= HALF_C) |-> irq);

    assert_irq_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[IRQ_RXH] && rx_cnt >= HALF_C) |-> irq);

    assert_no_rx_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> rx_cnt != FULL_C);

    assert_idle_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == '0 && cs_n) |=> cs_n);

endmodule

// File: tb/ssp_master_tb.sv
module ssp_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:2] addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, unsupported, sclk, cs_n, mosi, miso;

    int vectors = 0;
    int fails = 0;
    int hi_clk = 0, mon_cnt = 0, cs_rises = 0;
    logic [15:0] mon_bits = '0;
    logic [31:0] d;

    localparam logic [63:0] IDV = 64'h5A3C_11E4_0007_C196;

    always #10 clk = ~clk;
    assign miso = ~mosi;

    ssp_master u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .unsupported(unsupported),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always @(posedge sclk) if (!cs_n) begin
        mon_bits = {mon_bits[14:0], mosi};
        mon_cnt++;
    end
    always @(negedge clk) if (sclk) hi_clk++;
    always @(posedge cs_n) cs_rises++;

    function automatic logic [15:0] fm(input int cfg);
        return 16'((32'd1 << (cfg + 1)) - 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] off, input logic [15:0] v);
        @(negedge clk);
        addr = off[11:2]; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] off, output logic [31:0] v);
        @(negedge clk);
        addr = off[11:2]; rd_en = 1'b1;
        #2 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(12'h00C, s);
            if ((s & 32'h11) == 32'h01) return;
        end
        check("R8 idle wait", 32'h1, 32'h0);
    endtask

    task automatic clr_mon();
        mon_bits = '0; mon_cnt = 0; hi_clk = 0; cs_rises = 0;
    endtask

    initial begin
        #(20 * 190000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [15:0] w [8];
        logic [15:0] exp11 [11];
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 cs_n", 32'(cs_n), 32'h1);
        check("R1 sclk", 32'(sclk), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rd(12'h00C, d); check("R1 R5 status", d, 32'h03);
        rd(12'h018, d); check("R1 R6 raw", d, 32'h08);
        rd(12'h008, d); check("R4 empty read zero", d, 32'h0);

        // R13 readback and identification bytes
        wr(12'h000, 16'h0007); rd(12'h000, d); check("R13 frame", d, 32'h7);
        wr(12'h004, 16'h0008); rd(12'h004, d); check("R13 ctrl", d, 32'h8);
        wr(12'h010, 16'h1234); rd(12'h010, d); check("R13 presc", d, 32'h34);
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(i * 4), d);
            check("R13 id", d, 32'(IDV[i*8 +: 8]));
        end

        // R3 overflow drop, R4 last value, R5/R6/R7
        wr(12'h004, 16'h0000); wr(12'h010, 16'h0002);
        for (int i = 1; i <= 9; i++) wr(12'h008, 16'(i * 16'h11));
        rd(12'h00C, d); check("R3 R5 tx full status", d, 32'h00);
        rd(12'h018, d); check("R6 raw tx above half", d, 32'h00);
        wr(12'h004, 16'h0003);
        wait_idle();
        rd(12'h00C, d); check("R5 rx full status", d, 32'h0F);
        rd(12'h018, d); check("R6 raw both", d, 32'h0C);
        wr(12'h014, 16'h0004);
        check("R7 irq rx", 32'(irq), 32'h1);
        rd(12'h01C, d); check("R7 masked", d, 32'h04);
        wr(12'h014, 16'h0000);
        check("R7 irq off", 32'(irq), 32'h0);
        for (int i = 1; i <= 8; i++) begin
            rd(12'h008, d); check("R3 R9 loop data", d, 32'(i * 16'h11));
        end
        rd(12'h008, d); check("R4 last value", d, 32'h88);

        // R2 masking
        wr(12'h000, 16'h0003); wr(12'h008, 16'hABCD);
        wait_idle();
        rd(12'h008, d); check("R2 four bits", d, 32'h000D);

        // R8 stall on receive full
        wr(12'h004, 16'h0000); wr(12'h000, 16'h0007);
        for (int i = 0; i < 11; i++) exp11[i] = 16'(8'h30 + i * 7);
        for (int i = 0; i < 8; i++) wr(12'h008, exp11[i]);
        wr(12'h004, 16'h0003);
        wait_idle();
        for (int i = 8; i < 11; i++) wr(12'h008, exp11[i]);
        repeat (300) @(negedge clk);
        rd(12'h00C, d); check("R8 stalled status", d, 32'h0E);
        for (int i = 0; i < 11; i++) begin
            for (int k = 0; k < 500; k++) begin
                rd(12'h00C, d);
                if (d[2]) break;
            end
            rd(12'h008, d); check("R8 order after stall", d, 32'(exp11[i]));
        end

        // R10 R11 serial form, no loopback
        wr(12'h004, 16'h0000); wr(12'h010, 16'h0004);
        clr_mon();
        wr(12'h004, 16'h0002);
        wr(12'h008, 16'h00A5); wr(12'h008, 16'h003C);
        rd(12'h00C, d); check("R11 busy", 32'(d[4]), 32'h1);
        wait_idle();
        check("R10 msb first", 32'(mon_bits), 32'hA53C);
        check("R10 bit count", 32'(mon_cnt), 32'd16);
        check("R11 high time", 32'(hi_clk), 32'd64);
        check("R11 cs held", 32'(cs_rises), 32'd1);
        rd(12'h008, d); check("R10 miso frame1", d, 32'h5A);
        rd(12'h008, d); check("R10 miso frame2", d, 32'hC3);
        wr(12'h010, 16'h0003);
        clr_mon();
        wr(12'h008, 16'h000F);
        wait_idle();
        check("R11 odd presc", 32'(hi_clk), 32'd16);
        rd(12'h008, d); check("R10 miso frame3", d, 32'hF0);

        // R12 slave request
        wr(12'h004, 16'h0006); wr(12'h008, 16'h0055);
        repeat (200) @(negedge clk);
        check("R12 flag", 32'(unsupported), 32'h1);
        check("R12 cs idle", 32'(cs_n), 32'h1);
        rd(12'h00C, d); check("R12 no start", d, 32'h02);
        wr(12'h004, 16'h0002);
        wait_idle();
        check("R12 flag clear", 32'(unsupported), 32'h0);
        rd(12'h008, d); check("R12 resumed", d, 32'hAA);

        // R9 R2 random loopback
        wr(12'h004, 16'h0003); wr(12'h010, 16'h0002);
        for (int it = 0; it < 20; it++) begin
            int cfg, n;
            cfg = $urandom_range(15, 0);
            n = $urandom_range(8, 1);
            wr(12'h000, 16'(cfg));
            for (int j = 0; j < n; j++) begin
                w[j] = 16'($urandom);
                wr(12'h008, w[j]);
            end
            wait_idle();
            for (int j = 0; j < n; j++) begin
                rd(12'h008, d); check("R9 R2 random loop", d, 32'(w[j] & fm(cfg)));
            end
            rd(12'h00C, d); check("R5 drained", d, 32'h03);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule